// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block is the read side of a memory device with a 16-bit data bus. A one-byte configuration word selects one of two read modes. In asynchronous mode, each address strobe returns one word, and that word stays on the output until chip select is released or another strobe arrives. In burst mode, the word at the start address is returned at once. A programmable wait follows, and then one word is returned on every clock. The addresses either run on linearly or wrap inside an aligned block of 4, 8, 16 or 32 words.

Words come from a small on-chip array that a preload port fills. The address that selects the configuration word returns the configuration word itself. This lets the host read back the latency it has set, even in the middle of a burst.

Top module: `burst_read_seq`

## Requirements
- R1: Reset leaves `dout_valid` and `dout_oe` low. The configuration word after reset is 8'h20: asynchronous mode, latency 4, continuous length. Reading address F221h in that state returns 16'h0020.
- R2: An address is captured on a clock edge that sees `cs_n`=0, `stb_n`=0 and `we_n`=1. After that edge, `dout` holds the addressed word and `dout_valid` and `dout_oe` are 1. In asynchronous mode the word and the valid flag are held for as long as `cs_n` stays low and no other strobe arrives.
- R3: An edge that sees `cs_n`=0, `stb_n`=0, `we_n`=0 and `addr`=F221h loads `cfg_wdata` into the configuration word. Bit 7 is the mode (1 = burst), bits 6:3 are the latency and bits 2:0 are the length code. A write cycle at any other address changes nothing. A write cycle returns no data.
- R4: A latency value written below 3 is stored as 3, and a value above 7 is stored as 7. The stored latency is always in the range 3 to 7.
- R5: In burst mode, the start word appears after the capture edge E0, with `dout_valid` high for that one cycle. `dout_valid` is then low for L-1 cycles, and word 1 appears after edge E0+L, where L is the stored latency.
- R6: After word 1, a new word follows on every clock and `dout_valid` stays high.
- R7: Length code 0 gives addresses start+k modulo 2^16. Codes 5 to 7 behave the same way.
- R8: Length codes 1, 2, 3 and 4 give N = 4, 8, 16 and 32. Word k then has the upper address bits of the start address and low log2(N) bits equal to (start+k) mod N.
- R9: A word whose address is F221h returns {8'h00, configuration word} in either mode, including when it falls inside a burst.
- R10: An edge that sees `cs_n`=1 ends any burst and clears `dout_valid` and `dout_oe` after that edge. Taking `cs_n` low again without a strobe outputs nothing.
- R11: A strobe during a burst restarts the sequence from the new address. This holds even on the edge where a burst word was due.
- R12: Preload writes land at index `pl_idx`. A read of address A returns the word at index A mod DEPTH (DEPTH = 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| stb_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Word address |
| cfg_wdata | input | 8 | Configuration write data |
| pl_we | input | 1 | Array preload write enable |
| pl_idx | input | 6 | Array preload index |
| pl_data | input | 16 | Array preload word |
| dout | output | 16 | Read data |
| dout_valid | output | 1 | Read data valid |
| dout_oe | output | 1 | Output drive enable |

## Verification
The hardest coincidence is a restart strobe that lands on the same edge as the end of the latency wait, where the sequencer would otherwise emit word 1. The bench starts a burst and counts exactly L edges. It places the new strobe on the emission edge, then expects the new start word followed by a fresh gap of L-1 cycles. A second case reads the configuration address inside a running burst, so the configuration readback and the normal stream must coexist on the output path.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int LAT_MIN   = 3;
  localparam int LAT_MAX   = 7;
  localparam int LAT_RESET = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_HOLD, PH_WAIT, PH_STREAM} phase_e;

  typedef struct packed {
    logic       sync_mode;
    logic [3:0] lat;
    logic [2:0] len;
  } cfg_t;

  function automatic logic [3:0] clamp_lat(input logic [3:0] v);
    if (v < 4'(LAT_MIN)) return 4'(LAT_MIN);
    if (v > 4'(LAT_MAX)) return 4'(LAT_MAX);
    return v;
  endfunction
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output cfg_t       cfg
);
  cfg_t wr_cfg;
  assign wr_cfg = cfg_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.sync_mode <= 1'b0;
      cfg.lat       <= 4'(LAT_RESET);
      cfg.len       <= 3'd0;
    end else if (wr_en) begin
      cfg.sync_mode <= wr_cfg.sync_mode;
      cfg.lat       <= clamp_lat(wr_cfg.lat);
      cfg.len       <= wr_cfg.len;
    end
  end
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] count,
  input  logic [2:0]        len,
  output logic [ADDR_W-1:0] word_addr
);
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    if (len >= 3'd1 && len <= 3'd4)
      keep_mask = (ADDR_W'(2) << len) - ADDR_W'(1);
    else
      keep_mask = '1;
  end

  assign sum       = start + count;
  assign word_addr = (start & ~keep_mask) | (sum & keep_mask);
endmodule

// File: rtl/brs_word_store.sv
module brs_word_store #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 16,
  parameter int              IDX_W    = 6,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hF221
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              stb_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              pl_we,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              dout_oe
);
  localparam int PAD_W = DATA_W - 8;

  cfg_t              cfg;
  phase_e            phase_q;
  logic [ADDR_W-1:0] start_q, cnt_q;
  logic [3:0]        wcnt_q;
  logic              sel_cfg_q;
  logic [7:0]        cfg_snap_q;
  logic [DATA_W-1:0] mem_rd;

  logic              capture, wr_cyc, cfg_wr, emit;
  logic [ADDR_W-1:0] gen_start, gen_count, word_addr;

  assign capture = !cs_n && !stb_n && we_n;
  assign wr_cyc  = !cs_n && !stb_n && !we_n;
  assign cfg_wr  = wr_cyc && (addr == CFG_ADDR);

  assign gen_start = capture ? addr : start_q;
  assign gen_count = capture ? '0   : cnt_q;

  assign emit = capture ||
                (!cs_n && stb_n && phase_q == PH_WAIT && wcnt_q == 4'd0) ||
                (!cs_n && stb_n && phase_q == PH_STREAM);

  brs_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .cfg     (cfg)
  );

  brs_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .start     (gen_start),
    .count     (gen_count),
    .len       (cfg.len),
    .word_addr (word_addr)
  );

  brs_word_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (pl_we),
    .wr_idx  (pl_idx),
    .wr_data (pl_data),
    .rd_en   (emit),
    .rd_idx  (word_addr[IDX_W-1:0]),
    .rd_data (mem_rd)
  );

  // Sequencer: a deasserted chip select beats everything, a write cycle
  // idles the reader, and a strobe always restarts from the new address.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      start_q    <= '0;
      cnt_q      <= '0;
      wcnt_q     <= '0;
      dout_valid <= 1'b0;
      dout_oe    <= 1'b0;
    end else if (cs_n || wr_cyc) begin
      phase_q    <= PH_IDLE;
      dout_valid <= 1'b0;
      dout_oe    <= 1'b0;
    end else if (capture) begin
      start_q    <= addr;
      cnt_q      <= ADDR_W'(1);
      wcnt_q     <= cfg.lat - 4'd1;
      dout_valid <= 1'b1;
      dout_oe    <= 1'b1;
      phase_q    <= cfg.sync_mode ? PH_WAIT : PH_HOLD;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (wcnt_q == 4'd0) begin
            dout_valid <= 1'b1;
            cnt_q      <= cnt_q + ADDR_W'(1);
            phase_q    <= PH_STREAM;
          end else begin
            dout_valid <= 1'b0;
            wcnt_q     <= wcnt_q - 4'd1;
          end
        end
        PH_STREAM: begin
          dout_valid <= 1'b1;
          cnt_q      <= cnt_q + ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_cfg_q  <= 1'b0;
      cfg_snap_q <= '0;
    end else if (emit) begin
      sel_cfg_q  <= (word_addr == CFG_ADDR);
      cfg_snap_q <= cfg;
    end
  end

  assign dout = sel_cfg_q ? {{PAD_W{1'b0}}, cfg_snap_q} : mem_rd;
endmodule

// File: rtl/burst_read_seq_checker.sv
module burst_read_seq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              stb_n,
  input logic              we_n,
  input logic              dout_valid,
  input logic              dout_oe,
  input logic              cfg_sync,
  input logic [3:0]        cfg_lat,
  input logic [2:0]        cfg_len,
  input logic              emit,
  input logic [ADDR_W-1:0] word_addr,
  input logic [ADDR_W-1:0] start_q
);
  logic rst_q = 1'b0;
  logic cap;
  assign cap = !cs_n && !stb_n && we_n;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst)
      p_reset_state_r1: assert (!dout_valid && !dout_oe && !cfg_sync && cfg_lat == 4'd4);
  end

  p_capture_drives_r2: assert property (@(posedge clk) disable iff (rst)
    cap |=> (dout_valid && dout_oe));

  p_lat_range_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_lat >= 4'd3 && cfg_lat <= 4'd7));

  p_first_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (cap && cfg_sync) ##1 (!cs_n && stb_n) |=> !dout_valid);

  p_wrap_block_r8: assert property (@(posedge clk) disable iff (rst)
    (emit && !cap && cfg_len >= 3'd1 && cfg_len <= 3'd4) |->
      ((word_addr >> (cfg_len + 3'd1)) == (start_q >> (cfg_len + 3'd1))));

  p_cs_release_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout_valid && !dout_oe));
endmodule

bind burst_read_seq burst_read_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .stb_n      (stb_n),
  .we_n       (we_n),
  .dout_valid (dout_valid),
  .dout_oe    (dout_oe),
  .cfg_sync   (cfg.sync_mode),
  .cfg_lat    (cfg.lat),
  .cfg_len    (cfg.len),
  .emit       (emit),
  .word_addr  (word_addr),
  .start_q    (start_q)
);

// File: tb/burst_read_seq_bench.sv
`timescale 1ns/1ps
module burst_read_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, stb_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        pl_we = 1'b0;
  logic [5:0]  pl_idx = '0;
  logic [15:0] pl_data = '0;
  logic [15:0] dout;
  logic        dout_valid, dout_oe;

  int n_chk = 0, n_fail = 0;
  logic [15:0] cfg_model = 16'h0020;

  always #2.5 clk = ~clk;

  burst_read_seq u_burst_read_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .stb_n(stb_n), .we_n(we_n),
    .addr(addr), .cfg_wdata(cfg_wdata), .pl_we(pl_we), .pl_idx(pl_idx),
    .pl_data(pl_data), .dout(dout), .dout_valid(dout_valid), .dout_oe(dout_oe)
  );

  typedef struct packed {
    logic [15:0] start;
    logic [2:0]  code;
    logic [3:0]  lat_wr;
    logic [3:0]  lat_eff;
    logic [15:0] exp3;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'h0002, 3'd1, 4'd3, 4'd3, 16'h0001},
    '{16'h0001, 3'd2, 4'd4, 4'd4, 16'h0004},
    '{16'h0015, 3'd3, 4'd7, 4'd7, 16'h0018},
    '{16'h003E, 3'd4, 4'd1, 4'd3, 16'h0021},
    '{16'h003E, 3'd0, 4'd9, 4'd7, 16'h0041},
    '{16'hFFFE, 3'd0, 4'd5, 4'd5, 16'h0001},
    '{16'h0007, 3'd5, 4'd0, 4'd3, 16'h000A},
    '{16'hF21F, 3'd0, 4'd6, 4'd6, 16'hF222}
  };

  function automatic logic [15:0] pre(input logic [5:0] i);
    return 16'hC300 ^ (16'(i) * 16'h0107);
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] a);
    return (a == 16'hF221) ? cfg_model : pre(a[5:0]);
  endfunction

  function automatic logic [15:0] model_addr(input logic [15:0] s, input logic [2:0] c,
                                             input int k);
    logic [15:0] m;
    m = (c >= 3'd1 && c <= 3'd4) ? ((16'd2 << c) - 16'd1) : 16'hFFFF;
    return (s & ~m) | ((s + 16'(k)) & m);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic strobe(input logic [15:0] a);
    @(negedge clk); cs_n = 1'b0; stb_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk); stb_n = 1'b1;
  endtask

  task automatic write_at(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; stb_n = 1'b0; we_n = 1'b0; addr = a; cfg_wdata = d;
    @(negedge clk); stb_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic release_cs;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk(!dout_valid && !dout_oe, "R10", {14'd0, dout_valid, dout_oe}, 16'h0000);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); pl_we = 1'b1; pl_idx = 6'(i); pl_data = pre(6'(i));
    end
    @(negedge clk); pl_we = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!dout_valid && !dout_oe, "R1", {14'd0, dout_valid, dout_oe}, 16'h0000);

    // R1 / R9: default configuration read back in asynchronous mode
    strobe(16'hF221);
    chk(dout == 16'h0020, "R1", dout, 16'h0020);
    chk(dout_valid && dout_oe, "R2", {14'd0, dout_valid, dout_oe}, 16'h0003);

    // R2 / R12: asynchronous word held while cs_n stays low
    strobe(16'h0005);
    for (int j = 0; j < 4; j++) begin
      chk(dout == pre(6'd5) && dout_valid, "R2", dout, pre(6'd5));
      @(negedge clk);
    end
    strobe(16'h0045);
    chk(dout == pre(6'd5), "R12", dout, pre(6'd5));

    // R3: write cycle to another address changes nothing, returns no data
    write_at(16'h1234, 8'hFF);
    chk(!dout_valid, "R3", {15'd0, dout_valid}, 16'h0000);
    strobe(16'hF221);
    chk(dout == 16'h0020, "R3", dout, 16'h0020);
    release_cs();

    // Table-driven burst cases: R4..R9, R11 (strobe during readback burst)
    for (int v = 0; v < 8; v++) begin
      write_at(16'hF221, {1'b1, VEC[v].lat_wr, VEC[v].code});
      cfg_model = {8'h00, 1'b1, VEC[v].lat_eff, VEC[v].code};
      strobe(16'hF221);
      chk(dout == cfg_model, "R4", dout, cfg_model);
      strobe(VEC[v].start);
      chk(dout_valid && dout == exp_word(VEC[v].start), "R5", dout, exp_word(VEC[v].start));
      for (int j = 1; j < int'(VEC[v].lat_eff); j++) begin
        @(negedge clk);
        chk(!dout_valid, "R5", {15'd0, dout_valid}, 16'h0000);
      end
      for (int k = 1; k < 10; k++) begin
        @(negedge clk);
        chk(dout_valid, "R6", {15'd0, dout_valid}, 16'h0001);
        chk(dout == exp_word(model_addr(VEC[v].start, VEC[v].code, k)),
            (VEC[v].code >= 3'd1 && VEC[v].code <= 3'd4) ? "R8" : "R7",
            dout, exp_word(model_addr(VEC[v].start, VEC[v].code, k)));
        if (k == 3)
          chk(dout == exp_word(VEC[v].exp3), "R9", dout, exp_word(VEC[v].exp3));
      end
      release_cs();
    end

    // R10: cs_n low again without a strobe produces nothing
    @(negedge clk); cs_n = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!dout_valid && !dout_oe, "R10", {14'd0, dout_valid, dout_oe}, 16'h0000);
    end

    // R11: restart strobe on the very edge word 1 was due
    write_at(16'hF221, {1'b1, 4'd5, 3'd2});
    cfg_model = {8'h00, 1'b1, 4'd5, 3'd2};
    strobe(16'h0010);
    for (int j = 1; j < 5; j++) @(negedge clk);
    stb_n = 1'b0; addr = 16'h0033;
    @(negedge clk); stb_n = 1'b1;
    chk(dout_valid && dout == pre(6'h33), "R11", dout, pre(6'h33));
    for (int j = 1; j < 5; j++) begin
      @(negedge clk);
      chk(!dout_valid, "R11", {15'd0, dout_valid}, 16'h0000);
    end
    @(negedge clk);
    chk(dout_valid && dout == pre(6'h34), "R11", dout, pre(6'h34));

    // R4 / R3: low latency clamps, mode returns to asynchronous
    write_at(16'hF221, 8'h00);
    cfg_model = 16'h0018;
    strobe(16'hF221);
    chk(dout == 16'h0018, "R4", dout, 16'h0018);
    @(negedge clk);
    chk(dout_valid && dout == 16'h0018, "R3", dout, 16'h0018);
    release_cs();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule